// File: doc/BRIEF.md
# Per-Time-Slot Loopback Selector

This block sits between a time-division system bus and a multi-link line-side framer interface. Two byte streams pass through it. The receive stream travels from the line toward the system, and the transmit stream travels from the system toward the line. Each byte carries a valid flag, a link number and a time-slot index. In normal operation every byte passes through with one cycle of registered latency, and its link and slot tags are copied along with it.

One slot can be looped back, selected by link number and time-slot number together. The system-facing loop returns the system's own byte for that slot to the system and sends a programmable idle byte to the line in its place. The line-facing loop does the reverse. When both loops are on, each direction carries the looped byte and the idle byte is not used. The looped byte is held in a one-byte store and is read out at the next occurrence of the selected slot, so it always comes from the previous frame.

The configuration inputs are copied into an active set only on a frame-start strobe. The strobe accompanies the first byte of a frame, so a selection never changes partway through a frame.

Top module: `tslb_loop_sel`

## Requirements
- R1: While reset is held, and on the first outputs after reset, both output valid flags are 0 and both output data buses are 0. The active configuration after reset is pass-through, with link 0 and slot 0 selected.
- R2: A byte whose link or slot differs from the active selection, or any byte while neither loop is enabled, appears on the opposite-side output one cycle later unchanged. Its link and slot tags are copied with it.
- R3: With the system loop enabled, a valid receive byte whose link and slot both match the selection leaves toward the system carrying the transmit byte captured at the previous valid occurrence of that link and slot.
- R4: With only the system loop enabled, a valid transmit byte at the selected link and slot leaves toward the line as the active idle byte.
- R5: With the line loop enabled, a valid transmit byte at the selected link and slot leaves toward the line carrying the receive byte captured at the previous valid occurrence of that link and slot.
- R6: With only the line loop enabled, a valid receive byte at the selected link and slot leaves toward the system as the active idle byte.
- R7: With both loops enabled, each direction carries its looped byte at the selected slot and neither carries the idle byte.
- R8: After a loop becomes enabled, its looped output gives the idle byte until a byte has been captured for it.
- R9: The loop enables, selection and idle byte are sampled only in a cycle where frame_start is 1, and they apply to that cycle's bytes. A change made in the middle of a frame has no effect until the next frame start.
- R10: Each output valid flag equals the matching input valid flag one cycle earlier. A byte presented with valid 0 is never captured into a loop store, even when its tags match the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Marks the first byte of a frame; configuration is sampled here |
| cfg_sys_loop | input | 1 | Enables the system-facing loop |
| cfg_line_loop | input | 1 | Enables the line-facing loop |
| cfg_slot | input | SLOT_W | Selected time slot |
| cfg_link | input | LINK_W | Selected link |
| cfg_idle | input | BYTE_W | Idle byte |
| rx_valid | input | 1 | Receive byte valid (line to system) |
| rx_link | input | LINK_W | Receive byte link |
| rx_slot | input | SLOT_W | Receive byte slot |
| rx_data | input | BYTE_W | Receive byte |
| tx_valid | input | 1 | Transmit byte valid (system to line) |
| tx_link | input | LINK_W | Transmit byte link |
| tx_slot | input | SLOT_W | Transmit byte slot |
| tx_data | input | BYTE_W | Transmit byte |
| sys_valid | output | 1 | Valid toward the system |
| sys_link | output | LINK_W | Link tag toward the system |
| sys_slot | output | SLOT_W | Slot tag toward the system |
| sys_data | output | BYTE_W | Byte toward the system |
| line_valid | output | 1 | Valid toward the line |
| line_link | output | LINK_W | Link tag toward the line |
| line_slot | output | SLOT_W | Slot tag toward the line |
| line_data | output | BYTE_W | Byte toward the line |

## Verification
The bench sweeps every loop mode against every selected position in a small frame of three links by four slots. The tag values include 0 and 31, and each mode is entered from a pass-through frame.

- **Read order of the loop store.** A store that is read after it is written in the same cycle would return the current frame's byte instead of the previous frame's.
- **First frame after enabling.** A design with no empty state would leak stale data instead of the idle byte.
- **Configuration timing.** Each mode is switched in the middle of the preceding frame, so a design that applies configuration immediately would replace a slot too early.
- **Invalid cycles.** A gap cycle after every frame carries matching tags and garbage data. A design that captures regardless of valid would loop that garbage back in the next frame.

// File: rtl/tslb_pkg.sv
// Package: shared defaults and direction indices for the per-slot loopback selector.
// Assumes: two byte streams only; index 0 heads to the system, index 1 to the line.
package tslb_pkg;

    localparam int TSLB_LINK_W = 5;
    localparam int TSLB_SLOT_W = 5;
    localparam int TSLB_BYTE_W = 8;
    localparam int TSLB_NDIR   = 2;

    // Direction index of a lane; also the index of the loop enable that owns it.
    localparam int DIR_TO_SYS  = 0;
    localparam int DIR_TO_LINE = 1;

endpackage

// File: rtl/tslb_cfg_shadow.sv
// Module: holds the active loopback configuration, reloaded only on frame start.
// Assumes: frame_start is high in the same cycle as the first byte of a frame,
// and that byte must already see the new configuration.
module tslb_cfg_shadow #(
    parameter int LINK_W = 5,
    parameter int SLOT_W = 5,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              in_sys_loop,
    input  logic              in_line_loop,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [LINK_W-1:0] in_link,
    input  logic [BYTE_W-1:0] in_idle,
    output logic              eff_sys_loop,
    output logic              eff_line_loop,
    output logic [SLOT_W-1:0] eff_slot,
    output logic [LINK_W-1:0] eff_link,
    output logic [BYTE_W-1:0] eff_idle,
    output logic              sel_move
);

    logic              act_sys_loop;
    logic              act_line_loop;
    logic [SLOT_W-1:0] act_slot;
    logic [LINK_W-1:0] act_link;
    logic [BYTE_W-1:0] act_idle;

    // Purpose: capture the configuration inputs at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sys_loop  <= 1'b0;
            act_line_loop <= 1'b0;
            act_slot      <= '0;
            act_link      <= '0;
            act_idle      <= '0;
        end else if (frame_start) begin
            act_sys_loop  <= in_sys_loop;
            act_line_loop <= in_line_loop;
            act_slot      <= in_slot;
            act_link      <= in_link;
            act_idle      <= in_idle;
        end
    end

    // Purpose: let the frame's first byte use the configuration being loaded.
    always_comb begin
        if (frame_start) begin
            eff_sys_loop  = in_sys_loop;
            eff_line_loop = in_line_loop;
            eff_slot      = in_slot;
            eff_link      = in_link;
            eff_idle      = in_idle;
        end else begin
            eff_sys_loop  = act_sys_loop;
            eff_line_loop = act_line_loop;
            eff_slot      = act_slot;
            eff_link      = act_link;
            eff_idle      = act_idle;
        end
    end

    // Purpose: flag a boundary at which the selected position moves.
    assign sel_move = frame_start && ((in_slot != act_slot) || (in_link != act_link));

endmodule

// File: rtl/tslb_slot_buffer.sv
// Module: one-byte loop store with a "holds data" flag.
// Assumes: cap is only raised while enable is high; a read in the same cycle
// as a capture returns the older byte (read before write).
module tslb_slot_buffer #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              flush,
    input  logic              cap,
    input  logic [BYTE_W-1:0] din,
    output logic              rd_ok,
    output logic [BYTE_W-1:0] rd_byte
);

    logic              held_ok;
    logic [BYTE_W-1:0] held;
    logic              drop_now;

    // Purpose: the stored byte is stale when the loop is off or the slot moved.
    assign drop_now = !enable || flush;

    // Purpose: capture a byte or forget the stored one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_ok <= 1'b0;
            held    <= '0;
        end else if (cap) begin
            held_ok <= 1'b1;
            held    <= din;
        end else if (drop_now) begin
            held_ok <= 1'b0;
        end
    end

    // Purpose: present the stored byte, hiding it as soon as it goes stale.
    assign rd_ok   = held_ok && !drop_now;
    assign rd_byte = held;

endmodule

// File: rtl/tslb_lane.sv
// Module: one output direction; picks pass-through, looped byte or idle byte
// for the selected slot and registers the result (one cycle latency).
// Assumes: hit is already qualified with the input valid flag.
module tslb_lane #(
    parameter int LINK_W = 5,
    parameter int SLOT_W = 5,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LINK_W-1:0] in_link,
    input  logic [SLOT_W-1:0] in_slot,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              hit,
    input  logic              use_loop,
    input  logic              use_idle,
    input  logic              loop_ok,
    input  logic [BYTE_W-1:0] loop_byte,
    input  logic [BYTE_W-1:0] idle_byte,
    output logic              out_valid,
    output logic [LINK_W-1:0] out_link,
    output logic [SLOT_W-1:0] out_slot,
    output logic [BYTE_W-1:0] out_data
);

    logic [BYTE_W-1:0] nxt_data;

    // Purpose: choose the byte leaving this lane.
    always_comb begin
        nxt_data = in_data;
        if (hit) begin
            if (use_loop) begin
                nxt_data = loop_ok ? loop_byte : idle_byte;
            end else if (use_idle) begin
                nxt_data = idle_byte;
            end
        end
    end

    // Purpose: register the byte and its tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_link  <= '0;
            out_slot  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            out_link  <= in_link;
            out_slot  <= in_slot;
            out_data  <= nxt_data;
        end
    end

endmodule

// File: rtl/tslb_loop_sel.sv
// Module: top of the per-slot loopback selector. Lane 0 carries receive bytes
// to the system, lane 1 carries transmit bytes to the line. Each lane's loop
// store is filled from the opposite stream at the selected link and slot.
// Assumes: both streams share the frame-start strobe; tags are in range.
module tslb_loop_sel
    import tslb_pkg::*;
#(
    parameter int LINK_W = TSLB_LINK_W,
    parameter int SLOT_W = TSLB_SLOT_W,
    parameter int BYTE_W = TSLB_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              cfg_sys_loop,
    input  logic              cfg_line_loop,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [LINK_W-1:0] cfg_link,
    input  logic [BYTE_W-1:0] cfg_idle,
    input  logic              rx_valid,
    input  logic [LINK_W-1:0] rx_link,
    input  logic [SLOT_W-1:0] rx_slot,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              tx_valid,
    input  logic [LINK_W-1:0] tx_link,
    input  logic [SLOT_W-1:0] tx_slot,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              sys_valid,
    output logic [LINK_W-1:0] sys_link,
    output logic [SLOT_W-1:0] sys_slot,
    output logic [BYTE_W-1:0] sys_data,
    output logic              line_valid,
    output logic [LINK_W-1:0] line_link,
    output logic [SLOT_W-1:0] line_slot,
    output logic [BYTE_W-1:0] line_data
);

    logic              eff_sys_loop;
    logic              eff_line_loop;
    logic [SLOT_W-1:0] eff_slot;
    logic [LINK_W-1:0] eff_link;
    logic [BYTE_W-1:0] eff_idle;
    logic              sel_move;

    logic              in_valid [TSLB_NDIR];
    logic [LINK_W-1:0] in_link  [TSLB_NDIR];
    logic [SLOT_W-1:0] in_slot  [TSLB_NDIR];
    logic [BYTE_W-1:0] in_data  [TSLB_NDIR];
    logic              hit      [TSLB_NDIR];
    logic              loop_en  [TSLB_NDIR];
    logic              loop_ok  [TSLB_NDIR];
    logic [BYTE_W-1:0] loop_byte[TSLB_NDIR];
    logic              out_valid[TSLB_NDIR];
    logic [LINK_W-1:0] out_link [TSLB_NDIR];
    logic [SLOT_W-1:0] out_slot [TSLB_NDIR];
    logic [BYTE_W-1:0] out_data [TSLB_NDIR];

    tslb_cfg_shadow #(
        .LINK_W(LINK_W),
        .SLOT_W(SLOT_W),
        .BYTE_W(BYTE_W)
    ) cfg_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .in_sys_loop  (cfg_sys_loop),
        .in_line_loop (cfg_line_loop),
        .in_slot      (cfg_slot),
        .in_link      (cfg_link),
        .in_idle      (cfg_idle),
        .eff_sys_loop (eff_sys_loop),
        .eff_line_loop(eff_line_loop),
        .eff_slot     (eff_slot),
        .eff_link     (eff_link),
        .eff_idle     (eff_idle),
        .sel_move     (sel_move)
    );

    // Purpose: gather both streams into direction-indexed arrays.
    always_comb begin
        in_valid[DIR_TO_SYS]  = rx_valid;
        in_link[DIR_TO_SYS]   = rx_link;
        in_slot[DIR_TO_SYS]   = rx_slot;
        in_data[DIR_TO_SYS]   = rx_data;
        in_valid[DIR_TO_LINE] = tx_valid;
        in_link[DIR_TO_LINE]  = tx_link;
        in_slot[DIR_TO_LINE]  = tx_slot;
        in_data[DIR_TO_LINE]  = tx_data;
        loop_en[DIR_TO_SYS]   = eff_sys_loop;
        loop_en[DIR_TO_LINE]  = eff_line_loop;
    end

    for (genvar d = 0; d < TSLB_NDIR; d++) begin : g_dir
        localparam int OPP = TSLB_NDIR - 1 - d;

        // Purpose: a valid byte sits at the selected link and slot.
        assign hit[d] = in_valid[d] && (in_link[d] == eff_link) && (in_slot[d] == eff_slot);

        tslb_slot_buffer #(
            .BYTE_W(BYTE_W)
        ) buf_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (loop_en[d]),
            .flush  (sel_move),
            .cap    (hit[OPP] && loop_en[d]),
            .din    (in_data[OPP]),
            .rd_ok  (loop_ok[d]),
            .rd_byte(loop_byte[d])
        );

        tslb_lane #(
            .LINK_W(LINK_W),
            .SLOT_W(SLOT_W),
            .BYTE_W(BYTE_W)
        ) lane_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_valid (in_valid[d]),
            .in_link  (in_link[d]),
            .in_slot  (in_slot[d]),
            .in_data  (in_data[d]),
            .hit      (hit[d]),
            .use_loop (loop_en[d]),
            .use_idle (loop_en[OPP] && !loop_en[d]),
            .loop_ok  (loop_ok[d]),
            .loop_byte(loop_byte[d]),
            .idle_byte(eff_idle),
            .out_valid(out_valid[d]),
            .out_link (out_link[d]),
            .out_slot (out_slot[d]),
            .out_data (out_data[d])
        );
    end

    // Purpose: drive the ports from the lane outputs.
    assign sys_valid  = out_valid[DIR_TO_SYS];
    assign sys_link   = out_link[DIR_TO_SYS];
    assign sys_slot   = out_slot[DIR_TO_SYS];
    assign sys_data   = out_data[DIR_TO_SYS];
    assign line_valid = out_valid[DIR_TO_LINE];
    assign line_link  = out_link[DIR_TO_LINE];
    assign line_slot  = out_slot[DIR_TO_LINE];
    assign line_data  = out_data[DIR_TO_LINE];

endmodule

// File: rtl/tslb_loop_sel_chk.sv
// Module: property checker for tslb_loop_sel, attached by bind below.
// Keeps its own frame-sampled view of the configuration from the ports.
module tslb_loop_sel_chk #(
    parameter int LINK_W = 5,
    parameter int SLOT_W = 5,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              cfg_sys_loop,
    input logic              cfg_line_loop,
    input logic [SLOT_W-1:0] cfg_slot,
    input logic [LINK_W-1:0] cfg_link,
    input logic [BYTE_W-1:0] cfg_idle,
    input logic              rx_valid,
    input logic [LINK_W-1:0] rx_link,
    input logic [SLOT_W-1:0] rx_slot,
    input logic [BYTE_W-1:0] rx_data,
    input logic              tx_valid,
    input logic [LINK_W-1:0] tx_link,
    input logic [SLOT_W-1:0] tx_slot,
    input logic [BYTE_W-1:0] tx_data,
    input logic              sys_valid,
    input logic [LINK_W-1:0] sys_link,
    input logic [SLOT_W-1:0] sys_slot,
    input logic [BYTE_W-1:0] sys_data,
    input logic              line_valid,
    input logic [LINK_W-1:0] line_link,
    input logic [SLOT_W-1:0] line_slot,
    input logic [BYTE_W-1:0] line_data
);

    logic              k_sys, k_line;
    logic [SLOT_W-1:0] k_slot;
    logic [LINK_W-1:0] k_link;
    logic [BYTE_W-1:0] k_idle;
    logic              v_sys, v_line;
    logic [SLOT_W-1:0] v_slot;
    logic [LINK_W-1:0] v_link;
    logic [BYTE_W-1:0] v_idle;
    logic              rx_at, tx_at;

    // Purpose: the checker's own frame-sampled configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_sys <= 1'b0; k_line <= 1'b0; k_slot <= '0; k_link <= '0; k_idle <= '0;
        end else if (frame_start) begin
            k_sys <= cfg_sys_loop; k_line <= cfg_line_loop;
            k_slot <= cfg_slot; k_link <= cfg_link; k_idle <= cfg_idle;
        end
    end

    assign v_sys  = frame_start ? cfg_sys_loop  : k_sys;
    assign v_line = frame_start ? cfg_line_loop : k_line;
    assign v_slot = frame_start ? cfg_slot      : k_slot;
    assign v_link = frame_start ? cfg_link      : k_link;
    assign v_idle = frame_start ? cfg_idle      : k_idle;
    assign rx_at  = rx_valid && rx_link == v_link && rx_slot == v_slot && (v_sys || v_line);
    assign tx_at  = tx_valid && tx_link == v_link && tx_slot == v_slot && (v_sys || v_line);

    assert_quiet_in_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!sys_valid && !line_valid && sys_data == '0 && line_data == '0));

    assert_rx_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_at) |=> (sys_data == $past(rx_data) && sys_link == $past(rx_link)
                                  && sys_slot == $past(rx_slot)));

    assert_tx_passes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_at) |=> (line_data == $past(tx_data) && line_link == $past(tx_link)
                                  && line_slot == $past(tx_slot)));

    assert_idle_to_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_at && v_sys && !v_line) |=> (line_data == $past(v_idle)));

    assert_idle_to_sys_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_at && v_line && !v_sys) |=> (sys_data == $past(v_idle)));

    assert_sys_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sys_valid == $past(rx_valid)));

    assert_line_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (line_valid == $past(tx_valid)));

endmodule

bind tslb_loop_sel tslb_loop_sel_chk #(
    .LINK_W(LINK_W),
    .SLOT_W(SLOT_W),
    .BYTE_W(BYTE_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_sys_loop(cfg_sys_loop), .cfg_line_loop(cfg_line_loop),
    .cfg_slot(cfg_slot), .cfg_link(cfg_link), .cfg_idle(cfg_idle),
    .rx_valid(rx_valid), .rx_link(rx_link), .rx_slot(rx_slot), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_link(tx_link), .tx_slot(tx_slot), .tx_data(tx_data),
    .sys_valid(sys_valid), .sys_link(sys_link), .sys_slot(sys_slot), .sys_data(sys_data),
    .line_valid(line_valid), .line_link(line_link), .line_slot(line_slot), .line_data(line_data)
);

// File: tb/tslb_loop_sel_tb_top.sv
// Bench: sweeps loop mode x selected position over a 3-link x 4-slot frame.
module tslb_loop_sel_tb_top;

    localparam int NL = 3;
    localparam int NS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       cfg_sys_loop = 1'b0, cfg_line_loop = 1'b0;
    logic [4:0] cfg_slot = '0, cfg_link = '0;
    logic [7:0] cfg_idle = '0;
    logic       rx_valid = 1'b0, tx_valid = 1'b0;
    logic [4:0] rx_link = '0, rx_slot = '0, tx_link = '0, tx_slot = '0;
    logic [7:0] rx_data = '0, tx_data = '0;
    logic       sys_valid, line_valid;
    logic [4:0] sys_link, sys_slot, line_link, line_slot;
    logic [7:0] sys_data, line_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    tslb_loop_sel dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cfg_sys_loop(cfg_sys_loop), .cfg_line_loop(cfg_line_loop),
        .cfg_slot(cfg_slot), .cfg_link(cfg_link), .cfg_idle(cfg_idle),
        .rx_valid(rx_valid), .rx_link(rx_link), .rx_slot(rx_slot), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_link(tx_link), .tx_slot(tx_slot), .tx_data(tx_data),
        .sys_valid(sys_valid), .sys_link(sys_link), .sys_slot(sys_slot), .sys_data(sys_data),
        .line_valid(line_valid), .line_link(line_link), .line_slot(line_slot), .line_data(line_data)
    );

    function automatic logic [4:0] link_of(int i);
        case (i) 0: return 5'd0; 1: return 5'd17; default: return 5'd31; endcase
    endfunction
    function automatic logic [4:0] slot_of(int i);
        case (i) 0: return 5'd0; 1: return 5'd9; 2: return 5'd22; default: return 5'd31; endcase
    endfunction
    function automatic logic [7:0] rxd(int g, int l, int s);
        return 8'((g * 37 + l * 11 + s * 5 + 3) % 256);
    endfunction
    function automatic logic [7:0] txd(int g, int l, int s);
        return 8'((g * 53 + l * 7 + s * 13 + 90) % 256);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int g;
        g = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet while in reset
        chk(!sys_valid && !line_valid, "R1 valid", {sys_valid, line_valid}, 0);
        chk(sys_data == 0 && line_data == 0, "R1 data", {sys_data, line_data}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(!sys_valid && !line_valid, "R1 after release", {sys_valid, line_valid}, 0);

        for (int sc = 0; sc < 36; sc++) begin
            int m, L, S;
            logic [7:0] idle;
            m    = sc / 12 + 1;
            L    = (sc % 12) % NL;
            S    = (sc % 12) / NL;
            idle = 8'(8'hA0 + sc);
            if (sc == 0) begin
                cfg_sys_loop = 1'b0; cfg_line_loop = 1'b0;
                cfg_link = link_of(L); cfg_slot = slot_of(S); cfg_idle = idle;
            end
            for (int fi = 0; fi < 4; fi++) begin
                bit sl, ll;
                sl = (fi > 0) && m[0];
                ll = (fi > 0) && m[1];
                for (int idx = 0; idx < NS * NL; idx++) begin
                    int l, s;
                    logic [7:0] es, el;
                    bit hit;
                    l = idx % NL;
                    s = idx / NL;
                    @(negedge clk);
                    // R9: change configuration mid-frame; must wait for next frame start
                    if (idx == 6 && fi == 0) begin
                        cfg_sys_loop = m[0]; cfg_line_loop = m[1];
                    end
                    if (idx == 6 && fi == 3 && sc < 35) begin
                        int nL, nS;
                        nL = ((sc + 1) % 12) % NL;
                        nS = ((sc + 1) % 12) / NL;
                        cfg_sys_loop = 1'b0; cfg_line_loop = 1'b0;
                        cfg_link = link_of(nL); cfg_slot = slot_of(nS);
                        cfg_idle = 8'(8'hA0 + sc + 1);
                    end
                    frame_start = (idx == 0);
                    rx_valid = 1'b1; tx_valid = 1'b1;
                    rx_link = link_of(l); rx_slot = slot_of(s); rx_data = rxd(g, l, s);
                    tx_link = link_of(l); tx_slot = slot_of(s); tx_data = txd(g, l, s);
                    hit = (l == L) && (s == S);
                    es = rxd(g, l, s);
                    el = txd(g, l, s);
                    if (hit && sl) es = (fi == 1) ? idle : txd(g - 1, l, s);   // R3 R7 R8
                    else if (hit && ll) es = idle;                              // R6
                    if (hit && ll) el = (fi == 1) ? idle : rxd(g - 1, l, s);   // R5 R7 R8
                    else if (hit && sl) el = idle;                              // R4
                    @(posedge clk);
                    #1;
                    chk(sys_valid && line_valid, "R10 valid", {sys_valid, line_valid}, 3);
                    chk(sys_link == link_of(l) && sys_slot == slot_of(s) &&
                        line_link == link_of(l) && line_slot == slot_of(s),
                        "R2 tags", {sys_link, sys_slot}, {link_of(l), slot_of(s)});
                    chk(sys_data == es, !hit ? "R2 sys pass" : (sl ? "R3 sys loop" : (ll ? "R6 sys idle" : "R9 sys")),
                        sys_data, es);
                    chk(line_data == el, !hit ? "R2 line pass" : (ll ? "R5 line loop" : (sl ? "R4 line idle" : "R9 line")),
                        line_data, el);
                end
                // R10: invalid gap cycle with matching tags and garbage data
                @(negedge clk);
                frame_start = 1'b0;
                rx_valid = 1'b0; tx_valid = 1'b0;
                rx_link = link_of(L); rx_slot = slot_of(S); rx_data = 8'hEE;
                tx_link = link_of(L); tx_slot = slot_of(S); tx_data = 8'hEE;
                @(posedge clk);
                #1;
                chk(!sys_valid && !line_valid, "R10 gap", {sys_valid, line_valid}, 0);
                g++;
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule